// File: doc/BRIEF.md
# Low Pin Count Bus I/O and DMA Target

This block sits on the target side of a Low Pin Count host link, clocked by the 33 MHz PCI clock. It watches the 4-bit shared address/data nibble bus and the active-low frame strobe. It claims single-byte I/O reads and writes whose 16-bit address lies in a configurable window. It also claims single-byte DMA transfers in either direction on one configured channel. Every other cycle passes by without the block touching the bus.

For a claimed cycle the block follows the two-clock turnaround rules. It reports progress with sync nibbles and, for reads, returns the data byte. On the local side it offers a plain byte port with address, write data, read data, separate write and read strobes and a ready input, so a register file can stretch the access with wait states. A frame strobe seen at any time ends the cycle in progress. The bus is released on the next clock and the block looks for a fresh start.

Top module: `lpcTarget`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises, `nibOe`, `regWrStb` and `regRdStb` are all 0; a reset applied in the middle of a cycle releases the bus at once.
- R2: A cycle begins only when the nibble on the last clock with `frameN` low is 4'b0000; any other value on that clock makes the block ignore the whole cycle.
- R3: The nibble after the start is decoded on bits [3:1]: 3'b000 I/O read, 3'b001 I/O write, 3'b100 DMA host-to-target, 3'b101 DMA target-to-host; any other code is ignored and the bus is never driven.
- R4: An I/O cycle sends its 16-bit address as four nibbles, most significant first. It is claimed only if IO_BASE <= address < IO_BASE+IO_SPAN; otherwise no strobe fires and the bus is never driven.
- R5: On a claimed write, the data byte arrives low nibble first, then high nibble, then two host turnaround clocks. After that the block enters sync with `regWrStb` high, `regWrData` holding the byte and `regAddr` holding the address.
- R6: Each sync clock drives 4'b0101 while `regReady` is low and 4'b0000 on the clock where `regReady` is high; the strobe stays high, with stable address and data, until that clock.
- R7: On a claimed read, `regRdData` is taken on the ready sync clock; its low nibble is driven on the next clock and its high nibble on the clock after.
- R8: After the last nibble it drives (the ready sync of a write, the high data nibble of a read) the block drives 4'b1111 for one clock and then releases the bus.
- R9: A DMA cycle is claimed only if channel nibble bits [2:0] equal DMA_CHAN and the size nibble after it is 4'b0000. During sync `regIsDma` is 1 and `regAddr` equals the channel nibble zero-extended.
- R10: When `frameN` is sampled low, `nibOe` is 0 and both strobes are 0 on the next clock; a new start accepted at that point runs as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| nibIn | input | 4 | Nibble sampled from the shared bus |
| nibOut | output | 4 | Nibble the target drives |
| nibOe | output | 1 | Output enable for `nibOut` |
| regAddr | output | 16 | I/O address or DMA channel nibble |
| regWrData | output | 8 | Byte to write to the register side |
| regRdData | input | 8 | Byte returned by the register side |
| regWrStb | output | 1 | Write request, held until ready |
| regRdStb | output | 1 | Read request, held until ready |
| regReady | input | 1 | Register side completes the access this clock |
| regIsDma | output | 1 | Current access is a DMA transfer |

## Verification
The first sync clock appears on the third clock after the last address nibble of a read, or after the high data nibble of a write. Each further wait adds one clock. Read data follows the ready sync by one and two clocks, the 4'b1111 turnaround by one more, and release by one after that. Bus release after a sampled frame strobe is due exactly one clock later. The bench drives each nibble before a rising edge and compares the enable, the nibble and both strobes at the following falling edge against the value its host model predicts for that clock. It sets `regReady` for a sync clock at the falling edge before that clock is compared.

// File: rtl/lpcTgtPkg.sv
package lpcTgtPkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int CNT_W     = $clog2(ADDR_NIBS);

  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_WAIT  = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_TURN  = 4'b1111;
  localparam logic [NIB_W-1:0] NIB_BYTE  = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_CHAN, ST_SIZE, ST_WLO, ST_WHI,
    ST_HTA0, ST_HTA1, ST_SYNC, ST_RLO, ST_RHI, ST_TTA, ST_SKIP
  } state_e;

  typedef enum logic [2:0] {
    DRV_OFF, DRV_WAIT, DRV_READY, DRV_DLO, DRV_DHI, DRV_TURN
  } drive_e;

  typedef struct packed {
    logic   addrClr;
    logic   addrShift;
    logic   dataLo;
    logic   dataHi;
    logic   rdLoad;
    drive_e drive;
  } ctrlStrb_t;
endpackage

// File: rtl/lpcTgtCtrl.sv
module lpcTgtCtrl
  import lpcTgtPkg::*;
#(
  parameter logic [2:0] DMA_CHAN = 3'd2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] nibIn,
  input  logic             addrHit,
  input  logic             regReady,
  output ctrlStrb_t        ctrl,
  output logic             regWrStb,
  output logic             regRdStb,
  output logic             regIsDma
);
  state_e           state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             isWr, isWrNxt, isDma, isDmaNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    isWrNxt  = isWr;
    isDmaNxt = isDma;
    ctrl     = '{default: '0, drive: DRV_OFF};
    case (state)
      ST_TYPE: begin
        cntNxt = '0;
        case (nibIn[3:1])
          3'b000:  begin isWrNxt = 1'b0; isDmaNxt = 1'b0; stateNxt = ST_ADDR; end
          3'b001:  begin isWrNxt = 1'b1; isDmaNxt = 1'b0; stateNxt = ST_ADDR; end
          3'b100:  begin isWrNxt = 1'b1; isDmaNxt = 1'b1; stateNxt = ST_CHAN; end
          3'b101:  begin isWrNxt = 1'b0; isDmaNxt = 1'b1; stateNxt = ST_CHAN; end
          default: stateNxt = ST_SKIP;
        endcase
      end
      ST_ADDR: begin
        ctrl.addrShift = 1'b1;
        cntNxt = cnt + 1'b1;
        if (cnt == CNT_W'(ADDR_NIBS - 1)) stateNxt = isWr ? ST_WLO : ST_HTA0;
      end
      ST_CHAN: begin
        ctrl.addrShift = 1'b1;
        stateNxt = (nibIn[2:0] == DMA_CHAN) ? ST_SIZE : ST_SKIP;
      end
      ST_SIZE: begin
        if (nibIn != NIB_BYTE) stateNxt = ST_SKIP;
        else                   stateNxt = isWr ? ST_WLO : ST_HTA0;
      end
      ST_WLO: begin
        if (!isDma && !addrHit) stateNxt = ST_SKIP;
        else begin ctrl.dataLo = 1'b1; stateNxt = ST_WHI; end
      end
      ST_WHI: begin ctrl.dataHi = 1'b1; stateNxt = ST_HTA0; end
      ST_HTA0: stateNxt = (!isDma && !addrHit) ? ST_SKIP : ST_HTA1;
      ST_HTA1: stateNxt = ST_SYNC;
      ST_SYNC: begin
        ctrl.drive = regReady ? DRV_READY : DRV_WAIT;
        if (regReady) begin
          ctrl.rdLoad = !isWr;
          stateNxt = isWr ? ST_TTA : ST_RLO;
        end
      end
      ST_RLO: begin ctrl.drive = DRV_DLO; stateNxt = ST_RHI; end
      ST_RHI: begin ctrl.drive = DRV_DHI; stateNxt = ST_TTA; end
      ST_TTA: begin ctrl.drive = DRV_TURN; stateNxt = ST_IDLE; end
      default: stateNxt = state;
    endcase
    if (!frameN) begin
      ctrl.addrClr = 1'b1;
      stateNxt = (nibIn == NIB_START) ? ST_TYPE : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      isDma <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      isWr  <= isWrNxt;
      isDma <= isDmaNxt;
    end
  end

  assign regWrStb = (state == ST_SYNC) && isWr;
  assign regRdStb = (state == ST_SYNC) && !isWr;
  assign regIsDma = isDma;

  AST_START_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (state == ST_TYPE || state == ST_IDLE)); // R2
endmodule

// File: rtl/lpcTgtDatapath.sv
module lpcTgtDatapath
  import lpcTgtPkg::*;
#(
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0380,
  parameter int                IO_SPAN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         ctrl,
  input  logic [NIB_W-1:0]  nibIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] dataReg,
  output logic              addrHit,
  output logic [NIB_W-1:0]  nibOut,
  output logic              nibOe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (ctrl.addrClr)        addrReg <= '0;
      else if (ctrl.addrShift) addrReg <= {addrReg[ADDR_W-NIB_W-1:0], nibIn};
      if (ctrl.rdLoad)      dataReg <= regRdData;
      else if (ctrl.dataLo) dataReg[NIB_W-1:0] <= nibIn;
      else if (ctrl.dataHi) dataReg[DATA_W-1:NIB_W] <= nibIn;
    end
  end

  assign addrHit = (32'(addrReg) >= 32'(IO_BASE)) &&
                   (32'(addrReg) <  32'(IO_BASE) + 32'(IO_SPAN));

  always_comb begin
    nibOe  = 1'b1;
    nibOut = NIB_TURN;
    case (ctrl.drive)
      DRV_WAIT:  nibOut = NIB_WAIT;
      DRV_READY: nibOut = NIB_READY;
      DRV_DLO:   nibOut = dataReg[NIB_W-1:0];
      DRV_DHI:   nibOut = dataReg[DATA_W-1:NIB_W];
      DRV_TURN:  nibOut = NIB_TURN;
      default:   begin nibOe = 1'b0; nibOut = '0; end
    endcase
  end

  always @(posedge clk) begin
    if (!rstN) AST_RESET_FLOAT: assert (!nibOe); // R1
  end
endmodule

// File: rtl/lpcTarget.sv
module lpcTarget
  import lpcTgtPkg::*;
#(
  parameter logic [15:0] IO_BASE  = 16'h0380,
  parameter int          IO_SPAN  = 16,
  parameter logic [2:0]  DMA_CHAN = 3'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic [3:0]  nibIn,
  output logic [3:0]  nibOut,
  output logic        nibOe,
  output logic [15:0] regAddr,
  output logic [7:0]  regWrData,
  input  logic [7:0]  regRdData,
  output logic        regWrStb,
  output logic        regRdStb,
  input  logic        regReady,
  output logic        regIsDma
);
  ctrlStrb_t ctrl;
  logic      addrHit;

  lpcTgtCtrl #(.DMA_CHAN(DMA_CHAN)) i_ctrl (
    .clk, .rstN, .frameN, .nibIn, .addrHit, .regReady,
    .ctrl, .regWrStb, .regRdStb, .regIsDma
  );

  lpcTgtDatapath #(.IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN)) i_dp (
    .clk, .rstN, .ctrl, .nibIn, .regRdData,
    .addrReg(regAddr), .dataReg(regWrData), .addrHit, .nibOut, .nibOe
  );

  AST_FRAME_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (!nibOe && !regWrStb && !regRdStb)); // R10
  AST_WAIT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ((regWrStb || regRdStb) && !regReady) |-> (nibOe && nibOut == 4'b0101)); // R6
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStb && !regReady && frameN) |=> (regWrStb && $stable(regWrData) && $stable(regAddr))); // R6
  AST_READ_LOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (regRdStb && regReady && frameN) |=> (nibOe && nibOut == $past(regRdData[3:0]))); // R7
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ((regWrStb || regRdStb) && !regIsDma) |->
      (32'(regAddr) >= 32'(IO_BASE) && 32'(regAddr) < 32'(IO_BASE) + 32'(IO_SPAN))); // R4
endmodule

// File: tb/test_lpcTarget.sv
module test_lpcTarget;
  localparam int CLK_PERIOD = 30;
  localparam logic [15:0] BASE = 16'h0380;
  localparam logic [2:0]  CHAN = 3'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic [3:0] nibIn = 4'hF;
  logic [7:0] regRdData = 8'h00;
  logic regReady = 1'b1;
  logic [3:0] nibOut;
  logic nibOe, regWrStb, regRdStb, regIsDma;
  logic [15:0] regAddr;
  logic [7:0] regWrData;
  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpcTarget #(.IO_BASE(BASE), .IO_SPAN(16), .DMA_CHAN(CHAN)) i_lpcTarget (
    .clk, .rstN, .frameN, .nibIn, .nibOut, .nibOe, .regAddr, .regWrData,
    .regRdData, .regWrStb, .regRdStb, .regReady, .regIsDma
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus clock: drive inputs, take the edge, compare the predicted outputs.
  task automatic clk1(input logic f, input logic [3:0] n, input logic eOe,
                      input logic [3:0] eNib, input logic eWr, input logic eRd,
                      input logic rdy, input string req);
    frameN = f;
    nibIn  = n;
    @(posedge clk);
    @(negedge clk);
    regReady = rdy;
    #1;
    check(nibOe === eOe && (!eOe || nibOut === eNib) && regWrStb === eWr && regRdStb === eRd,
          req, {nibOe, nibOut, regWrStb, regRdStb}, {eOe, eNib, eWr, eRd});
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, req);
  endtask

  task automatic syncLoop(input bit wr, input int waits, input logic [15:0] eAddr,
                          input logic [7:0] eData, input bit dma, input string req);
    for (int i = 0; i <= waits; i++) begin
      clk1(1'b1, 4'hF, 1'b1, (i < waits) ? 4'b0101 : 4'b0000, wr, !wr, i == waits, req);
      check(regAddr === eAddr && regIsDma === dma, req, {regIsDma, regAddr}, {dma, eAddr});
      if (wr) check(regWrData === eData, req, regWrData, eData);
    end
  endtask

  task automatic startType(input logic [3:0] ct);
    clk1(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R2");
    clk1(1'b1, ct, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R3");
  endtask

  task automatic sendAddr(input logic [15:0] a);
    for (int k = 3; k >= 0; k--) clk1(1'b1, a[4*k +: 4], 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R4");
  endtask

  task automatic writeTail(input logic [15:0] eAddr, input logic [7:0] d, input int waits,
                           input bit dma, input string req);
    clk1(1'b1, d[3:0], 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    clk1(1'b1, d[7:4], 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    syncLoop(1'b1, waits, eAddr, d, dma, req);
    clk1(1'b1, 4'hF, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, "R8");
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R8");
  endtask

  task automatic readTail(input logic [15:0] eAddr, input logic [7:0] rd, input int waits,
                          input bit dma, input string req);
    regRdData = rd;
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R7");
    syncLoop(1'b0, waits, eAddr, 8'h00, dma, req);
    clk1(1'b1, 4'hF, 1'b1, rd[3:0], 1'b0, 1'b0, 1'b1, "R7");
    regRdData = ~rd;
    clk1(1'b1, 4'hF, 1'b1, rd[7:4], 1'b0, 1'b0, 1'b1, "R7");
    clk1(1'b1, 4'hF, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, "R8");
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(!nibOe && !regWrStb && !regRdStb, "R1 in reset", {nibOe, regWrStb, regRdStb}, 0);
    rstN = 1'b1;
    quiet(2, "R1");

    // I/O write, no wait, low edge of window
    startType(4'b0010); sendAddr(16'h0380); writeTail(16'h0380, 8'hA5, 0, 1'b0, "R5");
    // I/O write with waits, high edge of window
    startType(4'b0011); sendAddr(16'h038F); writeTail(16'h038F, 8'h3C, 3, 1'b0, "R6");
    // I/O read, no wait and with waits
    startType(4'b0000); sendAddr(16'h0384); readTail(16'h0384, 8'h7E, 0, 1'b0, "R7");
    startType(4'b0001); sendAddr(16'h0381); readTail(16'h0381, 8'hC3, 2, 1'b0, "R6");
    // out-of-window accesses
    startType(4'b0010); sendAddr(16'h0390); quiet(10, "R4 above window");
    startType(4'b0000); sendAddr(16'h037F); quiet(10, "R4 below window");
    // unsupported cycle type
    startType(4'b0100); quiet(12, "R3 unsupported type");
    startType(4'b1110); quiet(12, "R3 unsupported type");
    // bad start nibble, then a would-be claimed write
    clk1(1'b0, 4'b0101, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R2 bad start");
    clk1(1'b1, 4'b0010, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R2 bad start");
    sendAddr(16'h0380); quiet(10, "R2 bad start");
    // DMA host-to-target and target-to-host
    startType(4'b1000);
    clk1(1'b1, {1'b1, CHAN}, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9");
    clk1(1'b1, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9");
    writeTail({12'h000, 1'b1, CHAN}, 8'h5A, 1, 1'b1, "R9");
    startType(4'b1010);
    clk1(1'b1, {1'b0, CHAN}, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9");
    clk1(1'b1, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9");
    readTail({12'h000, 1'b0, CHAN}, 8'h96, 0, 1'b1, "R9");
    // DMA wrong channel, wrong size
    startType(4'b1000);
    clk1(1'b1, 4'b0011, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9 channel");
    quiet(10, "R9 wrong channel");
    startType(4'b1010);
    clk1(1'b1, {1'b0, CHAN}, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9 size");
    clk1(1'b1, 4'b0001, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R9 size");
    quiet(10, "R9 wrong size");
    // abort during read sync, then an immediate new cycle
    startType(4'b0000); sendAddr(16'h0382);
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R10");
    clk1(1'b1, 4'hF, 1'b1, 4'b0101, 1'b0, 1'b1, 1'b0, "R10");
    clk1(1'b1, 4'hF, 1'b1, 4'b0101, 1'b0, 1'b1, 1'b0, "R10");
    clk1(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R10 release");
    startType(4'b0010); sendAddr(16'h0386); writeTail(16'h0386, 8'h11, 0, 1'b0, "R10 restart");
    // abort during write data with frame low carrying a start
    startType(4'b0010); sendAddr(16'h0380);
    clk1(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R10");
    clk1(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R10 restart");
    clk1(1'b1, 4'b0000, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R10 restart");
    sendAddr(16'h0388); readTail(16'h0388, 8'hE1, 1, 1'b0, "R10 restart");
    // reset in the middle of a write sync
    startType(4'b0010); sendAddr(16'h0380);
    clk1(1'b1, 4'h1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    clk1(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    clk1(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, "R5");
    clk1(1'b1, 4'hF, 1'b1, 4'b0101, 1'b1, 1'b0, 1'b0, "R6");
    rstN = 1'b0;
    #1;
    check(!nibOe && !regWrStb && !regRdStb, "R1 mid-cycle reset", {nibOe, regWrStb, regRdStb}, 0);
    regReady = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    quiet(2, "R1 after reset");
    startType(4'b0010); sendAddr(16'h0383); writeTail(16'h0383, 8'h42, 0, 1'b0, "R1 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule